// File: doc/BRIEF.md
# Checkpoint Undo-Log Memory Controller

This controller owns a small on-chip memory and keeps it recoverable. Between checkpoints, the first write to any line saves that line's old contents, together with its address, into an internal undo log. Only after that does the new data land. A per-line marker records that the line has been saved in the current interval, so later writes to the same line go straight to memory.

A checkpoint is committed in two steps. The first `commitReq` pulse puts the controller into a pending state in which requests are held off. The second pulse makes the checkpoint final. At that point the log region older than the previous checkpoint is released and all line markers are cleared. The log therefore always covers the two most recent final checkpoints.

A `rollbackReq` pulse replays the retained log from the newest entry to the oldest. This returns the memory to the older of the two retained checkpoints, so an error that is only noticed one interval late can still be undone. If the log fills before a commit, `overflow` rises and writes stall until a commit releases space.

Top module: `ckpt_undo_ctrl`

## Requirements
- R1: After reset, every line reads as zero, `busy`, `done`, `ckptPending` and `overflow` are low, and `reqReady` is high.
- R2: A read accepted on a clock edge (`reqValid` and `reqReady` high, `reqWrite` low) returns the line contents on `rdData`, with `rdValid` high for the one cycle after that edge.
- R3: A write accepted to a line whose marker is clear takes two cycles. `reqReady` is low in the cycle after acceptance while the old contents and address are appended to the log. After that the line holds the new data and its marker is set.
- R4: A write accepted to a line whose marker is set updates the memory without adding a log entry, and `reqReady` is high again in the following cycle.
- R5: A `commitReq` pulse while idle sets `ckptPending` and `busy` from the next cycle on, and holds `reqReady` low, until a second `commitReq` pulse.
- R6: The second `commitReq` pulse clears `ckptPending` and `busy` and raises `done` for exactly one cycle. It clears every line marker, so the next write to any line is logged again.
- R7: A rollback restores the memory to its contents at the second-most-recent final commit. If fewer than two final commits have happened since reset or since the last rollback, it restores the memory to its contents at that reset or rollback.
- R8: Rollback restores entries from the newest to the oldest, so a line logged in both retained intervals ends with its oldest saved value. With N retained entries, `busy` is high for N+1 cycles after the request cycle and is then followed by a one-cycle `done`.
- R9: When the retained entries equal the log depth (8 by default), `overflow` is high and writes are not accepted, while reads still are. A final commit that releases the older region clears `overflow`.
- R10: `rollbackReq` has priority over `commitReq` in the same cycle. A rollback requested while a commit is pending abandons the commit and clears `ckptPending`.
- R11: After a rollback completes, every line marker is clear, and the retained log is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (4) | Line address |
| reqWdata | input | DATA_W (8) | Write data |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| rdValid | output | 1 | Read data valid |
| rdData | output | DATA_W (8) | Read data |
| commitReq | input | 1 | Commit step pulse |
| rollbackReq | input | 1 | Rollback request pulse |
| busy | output | 1 | Commit pending or rollback in progress |
| done | output | 1 | One-cycle pulse at the end of a final commit or rollback |
| ckptPending | output | 1 | First commit step taken, second awaited |
| overflow | output | 1 | Log full, writes stalled |

## Verification
Write streams are built in several shapes:
- Repeated writes to one line within an interval separate logged writes from direct ones through the `reqReady` stall pattern.
- A line rewritten across a commit gets entries in both retained intervals, so only newest-to-oldest replay gives the right value after rollback.
- Two commit pairs between writes, followed by a rollback, show whether the target is the older retained checkpoint or the reset image.
- Filling the log across a commit, then committing again, exercises the stall and the release of space.
- Simultaneous or interleaved commit and rollback pulses show which one takes priority.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  // Strobes from the sequencer to the storage datapath, one per operation.
  typedef struct packed {
    logic capture;      // latch address and data of a write that needs logging
    logic directWrite;  // write to a line already saved this interval
    logic appendWrite;  // save old line to the log and write the new data
    logic readOut;      // drive read data
    logic restoreStep;  // replay newest log entry and drop it
    logic commitFinal;  // release older region, clear markers
    logic rollEnd;      // rollback finished, reset regions and markers
  } dpStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_APPEND  = 2'd1,
    ST_PENDING = 2'd2,
    ST_ROLL    = 2'd3
  } ctrlState_t;
endpackage

// File: rtl/ckpt_datapath.sv
module ckpt_datapath
  import ckpt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int LOG_DEPTH = 8   // power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              lineLogged,
  output logic              logFull,
  output logic              logEmpty,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int LINES = 1 << ADDR_W;
  localparam int IDX_W = $clog2(LOG_DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [DATA_W-1:0] memArr  [LINES];
  logic [ADDR_W-1:0] logAddr [LOG_DEPTH];
  logic [DATA_W-1:0] logData [LOG_DEPTH];
  logic [LINES-1:0]  loggedBits;
  logic [PTR_W-1:0]  headPtr, midPtr, tailPtr, fillCnt;
  logic [IDX_W-1:0]  headIdx, topIdx;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;

  assign headIdx    = headPtr[IDX_W-1:0];
  assign topIdx     = headIdx - IDX_W'(1);
  assign fillCnt    = headPtr - tailPtr;
  assign logFull    = (fillCnt == PTR_W'(LOG_DEPTH));
  assign logEmpty   = (headPtr == tailPtr);
  assign lineLogged = loggedBits[reqAddr];

  // Memory array: three write sources, never active together.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) memArr[i] <= '0;
    end else if (strobes.directWrite) begin
      memArr[reqAddr] <= reqWdata;
    end else if (strobes.appendWrite) begin
      memArr[capAddr] <= capData;
    end else if (strobes.restoreStep) begin
      memArr[logAddr[topIdx]] <= logData[topIdx];
    end
  end

  // Log storage, old contents are read before the same-edge overwrite.
  always_ff @(posedge clk) begin
    if (strobes.appendWrite) begin
      logAddr[headIdx] <= capAddr;
      logData[headIdx] <= memArr[capAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      capAddr <= reqAddr;
      capData <= reqWdata;
    end
  end

  // Region pointers and per-line markers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr    <= '0;
      midPtr     <= '0;
      tailPtr    <= '0;
      loggedBits <= '0;
    end else if (strobes.appendWrite) begin
      headPtr             <= headPtr + PTR_W'(1);
      loggedBits[capAddr] <= 1'b1;
    end else if (strobes.restoreStep) begin
      headPtr <= headPtr - PTR_W'(1);
    end else if (strobes.commitFinal) begin
      tailPtr    <= midPtr;
      midPtr     <= headPtr;
      loggedBits <= '0;
    end else if (strobes.rollEnd) begin
      midPtr     <= tailPtr;
      loggedBits <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.readOut;
      if (strobes.readOut) rdData <= memArr[reqAddr];
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= PTR_W'(LOG_DEPTH));
  a_r9_no_capture_when_full: assert property (@(posedge clk) disable iff (!rstN)
    logFull |-> !strobes.capture);
  a_r3_append_advances: assert property (@(posedge clk) disable iff (!rstN)
    strobes.appendWrite |=> headPtr == $past(headPtr) + PTR_W'(1));
  a_r4_direct_keeps_log: assert property (@(posedge clk) disable iff (!rstN)
    strobes.directWrite |=> headPtr == $past(headPtr));
  a_r6_final_clears_markers: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitFinal |=> loggedBits == '0);
  a_r8_restore_retreats: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restoreStep |=> headPtr == $past(headPtr) - PTR_W'(1));
  a_r11_roll_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rollEnd |=> (headPtr == tailPtr) && (midPtr == tailPtr) && (loggedBits == '0));
endmodule

// File: rtl/ckpt_control.sv
module ckpt_control
  import ckpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       commitReq,
  input  logic       rollbackReq,
  input  logic       lineLogged,
  input  logic       logFull,
  input  logic       logEmpty,
  output dpStrobes_t strobes,
  output logic       reqReady,
  output logic       busy,
  output logic       done,
  output logic       ckptPending
);
  ctrlState_t state, nextState;
  logic       doneNext;

  always_comb begin
    strobes   = '0;
    nextState = state;
    doneNext  = 1'b0;
    reqReady  = (state == ST_IDLE) && !rollbackReq && !commitReq &&
                !(reqWrite && logFull);
    unique case (state)
      ST_IDLE: begin
        if (rollbackReq)      nextState = ST_ROLL;
        else if (commitReq)   nextState = ST_PENDING;
        else if (reqValid && reqReady) begin
          if (!reqWrite)       strobes.readOut     = 1'b1;
          else if (lineLogged) strobes.directWrite = 1'b1;
          else begin
            strobes.capture = 1'b1;
            nextState       = ST_APPEND;
          end
        end
      end
      ST_APPEND: begin
        strobes.appendWrite = 1'b1;
        nextState           = ST_IDLE;
      end
      ST_PENDING: begin
        if (rollbackReq) nextState = ST_ROLL;
        else if (commitReq) begin
          strobes.commitFinal = 1'b1;
          doneNext            = 1'b1;
          nextState           = ST_IDLE;
        end
      end
      ST_ROLL: begin
        if (logEmpty) begin
          strobes.rollEnd = 1'b1;
          doneNext        = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          strobes.restoreStep = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNext;
    end
  end

  assign busy        = (state == ST_PENDING) || (state == ST_ROLL);
  assign ckptPending = (state == ST_PENDING);

  a_r5_busy_blocks_req: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));
  a_r10_rollback_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) || (state == ST_PENDING)) && rollbackReq |=> state == ST_ROLL);
  a_r3_append_stalls: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !reqReady);
endmodule

// File: rtl/ckpt_undo_ctrl.sv
module ckpt_undo_ctrl
  import ckpt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int LOG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              commitReq,
  input  logic              rollbackReq,
  output logic              busy,
  output logic              done,
  output logic              ckptPending,
  output logic              overflow
);
  dpStrobes_t strobes;
  logic lineLogged, logFull, logEmpty;

  ckpt_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .commitReq(commitReq), .rollbackReq(rollbackReq),
    .lineLogged(lineLogged), .logFull(logFull), .logEmpty(logEmpty),
    .strobes(strobes), .reqReady(reqReady), .busy(busy), .done(done),
    .ckptPending(ckptPending)
  );

  ckpt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .lineLogged(lineLogged), .logFull(logFull),
    .logEmpty(logEmpty), .rdValid(rdValid), .rdData(rdData)
  );

  assign overflow = logFull;
endmodule

// File: tb/tb_ckpt_undo_ctrl.sv
module tb_ckpt_undo_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       reqReady, rdValid;
  logic [7:0] rdData;
  logic       commitReq = 1'b0, rollbackReq = 1'b0;
  logic       busy, done, ckptPending, overflow;

  ckpt_undo_ctrl dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0] refMem [16];
  logic [7:0] ckOld  [16];
  logic [7:0] ckPrev [16];
  bit         markModel [16];
  int         oldN = 0, curN = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMarks();
    for (int i = 0; i < 16; i++) markModel[i] = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    #1 check(reqReady == 1'b1, req, reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1 check(rdValid == 1'b1 && rdData == exp, req, rdData, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
    bit expLog;
    expLog = !markModel[a];
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    #1 check(reqReady == 1'b1, req, reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1 check(reqReady == !expLog, req, reqReady, !expLog);
    if (expLog) begin
      @(negedge clk);
      curN++;
      markModel[a] = 1'b1;
    end
    refMem[a] = d;
  endtask

  task automatic commitPair(input string req);
    @(negedge clk); commitReq = 1'b1;
    @(negedge clk); commitReq = 1'b0;
    #1 check(ckptPending && busy && !reqReady, "R5 first step", ckptPending, 1);
    @(negedge clk);
    #1 check(ckptPending && busy, "R5 holds pending", busy, 1);
    commitReq = 1'b1;
    @(negedge clk); commitReq = 1'b0;
    #1 check(done && !ckptPending && !busy, req, done, 1);
    @(negedge clk);
    #1 check(!done, "R6 done one cycle", done, 0);
    for (int i = 0; i < 16; i++) begin ckOld[i] = ckPrev[i]; ckPrev[i] = refMem[i]; end
    oldN = curN; curN = 0;
    clearMarks();
  endtask

  // Rollback; withCommit drives commitReq in the same cycle (R10).
  task automatic rollback(input bit withCommit, input string req);
    int cyc;
    int total;
    total = oldN + curN;
    @(negedge clk); rollbackReq = 1'b1; commitReq = withCommit;
    @(negedge clk); rollbackReq = 1'b0; commitReq = 1'b0;
    #1;
    cyc = 0;
    while (busy && cyc < 100) begin
      check(!ckptPending, "R10 not pending during rollback", ckptPending, 0);
      cyc++;
      @(negedge clk); #1;
    end
    check(cyc == total + 1, "R8 busy length", cyc, total + 1);
    check(done == 1'b1, "R8 done after rollback", done, 1);
    for (int i = 0; i < 16; i++) begin refMem[i] = ckOld[i]; ckPrev[i] = ckOld[i]; end
    oldN = 0; curN = 0;
    clearMarks();
    for (int i = 0; i < 16; i++) rd(4'(i), refMem[i], req);
  endtask

  task automatic testReset();
    check(!busy && !done && !ckptPending && !overflow, "R1 status idle", busy, 0);
    check(reqReady == 1'b1, "R1 ready", reqReady, 1);
    rd(4'd0, 8'h00, "R1 zero line 0");
    rd(4'd15, 8'h00, "R1 zero line 15");
  endtask

  task automatic testWritesAndOrder();
    wr(4'd3, 8'hA1, "R3 first write logs");
    wr(4'd3, 8'hA2, "R4 repeat write direct");
    wr(4'd5, 8'hB1, "R3 second line logs");
    rd(4'd3, 8'hA2, "R2 read back");
    commitPair("R6 final commit");
    wr(4'd3, 8'hC1, "R6 marker cleared, logs again");
    wr(4'd7, 8'hD1, "R3 new interval");
    rollback(1'b0, "R8 newest-to-oldest reaches reset image");
    wr(4'd3, 8'hE1, "R11 marker clear after rollback");
  endtask

  task automatic testTwoCheckpoints();
    commitPair("R6 commit A");
    wr(4'd3, 8'hF1, "R3 write after A");
    commitPair("R6 commit B");
    wr(4'd3, 8'h11, "R3 write after B");
    wr(4'd9, 8'h22, "R3 other line after B");
    rollback(1'b0, "R7 restore older retained checkpoint");
  endtask

  task automatic testOverflow();
    for (int i = 0; i < 4; i++) wr(4'(i), 8'(8'h30 + i), "R3 fill first half");
    commitPair("R6 commit before fill");
    for (int i = 0; i < 4; i++) wr(4'(i), 8'(8'h40 + i), "R3 fill second half");
    #1 check(overflow == 1'b1, "R9 overflow at full", overflow, 1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 4'd10; reqWdata = 8'h99;
    #1 check(reqReady == 1'b0, "R9 write stalled", reqReady, 0);
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    rd(4'd10, refMem[10], "R9 stalled write had no effect, read allowed");
    commitPair("R6 commit releases space");
    #1 check(overflow == 1'b0, "R9 overflow cleared", overflow, 0);
  endtask

  task automatic testPriority();
    wr(4'd12, 8'h5A, "R3 before priority test");
    rollback(1'b1, "R10 rollback beats commit");
    wr(4'd12, 8'h6B, "R11 logs again");
    @(negedge clk); commitReq = 1'b1;
    @(negedge clk); commitReq = 1'b0;
    #1 check(ckptPending == 1'b1, "R10 pending before abort", ckptPending, 1);
    rollback(1'b0, "R10 rollback abandons pending commit");
    rollback(1'b0, "R8 empty log rollback");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin refMem[i] = 0; ckOld[i] = 0; ckPrev[i] = 0; end
    clearMarks();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testWritesAndOrder();
    testTwoCheckpoints();
    testOverflow();
    testPriority();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule